// File: doc/BRIEF.md
# Shadow Register Sync Hold-Off

This block lines up two timed events across channels: a channel start and a frequency hop of an oscillator tuning word. Software places the next tuning word in a shadow register and programs a 16-bit hold-off count for each of the two functions. The tuning word does nothing yet. A sync event then arms a countdown. When the countdown runs out, the hop function copies the shadow word into the active register and issues a one-cycle hop pulse. The start function issues a one-cycle start pulse and leaves the tuning word alone.

A sync event for each function comes from one of two places. It can be a software strobe. It can also be the rising edge of one of four external sync pins, chosen by a per-function select and gated by a per-function pin enable. The external pins are asynchronous, so each passes through a two-flop synchronizer and an edge detector before it is used. While a countdown is running, any further sync for that function is discarded. The oscillator that consumes the active word lies outside this block.

Top module: `syncHoldOff`

## Requirements
- R1: After reset, `activeFreq` is 0, both pulses are low, both busy flags are low, and both hold-off counts are 0.
- R2: A write to the shadow word through `freqWrEn`/`freqWrData` leaves `activeFreq` unchanged. `activeFreq` changes only on the clock edge that raises `hopPulse`.
- R3: Let a software sync (`softHop` or `softStart`) be sampled high on edge t while that function is idle, with programmed count N ≥ 1. Busy is then high after edge t through edge t+N-1. On edge t+N busy falls and the pulse is high for exactly the following cycle.
- R4: A programmed count of 0 behaves like a count of 1. The pulse follows the cycle after the sync.
- R5: On the hop edge, `activeFreq` takes the shadow value held just before that edge. A shadow write that lands on the hop edge itself is not taken. `hopPulse` never lasts longer than one cycle.
- R6: The start function runs the same countdown from its own count and strobe, drives only `startPulse`/`startBusy`, and never changes `activeFreq`.
- R7: A pin select of 0, 1, 2 or 3 picks `syncPins[0]`, `[1]`, `[2]` or `[3]` (pins A to D). With the pin enable set, a rising edge first seen before edge e acts as a sync on edge e+2. A pin held high does not sync again. Pins that are not selected are ignored.
- R8: A sync for a function that arrives while that function is busy is ignored. This includes a sync sampled on the expiry edge. The pulse timing and the pulse count are unchanged.
- R9: Writing a hold-off count during a countdown does not alter that countdown. The new value applies to the next sync.
- R10: With a function's pin enable low, edges on its selected pin do not sync it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| freqWrEn | input | 1 | Write strobe for the shadow tuning word |
| freqWrData | input | FREQ_W | Shadow tuning word value |
| startCntWrEn | input | 1 | Write strobe for the start hold-off count |
| hopCntWrEn | input | 1 | Write strobe for the hop hold-off count |
| cntWrData | input | CNT_W | Hold-off count value |
| softStart | input | 1 | Software sync strobe for the start function |
| softHop | input | 1 | Software sync strobe for the hop function |
| syncPins | input | NUM_PINS | Asynchronous external sync pins (bit 0 = A) |
| startPinEn | input | 1 | Lets the selected pin sync the start function |
| startPinSel | input | SEL_W | Pin index for the start function |
| hopPinEn | input | 1 | Lets the selected pin sync the hop function |
| hopPinSel | input | SEL_W | Pin index for the hop function |
| activeFreq | output | FREQ_W | Active tuning word sent to the oscillator |
| hopPulse | output | 1 | One-cycle pulse when the hop transfer happens |
| startPulse | output | 1 | One-cycle channel start pulse |
| startBusy | output | 1 | Start countdown in progress |
| hopBusy | output | 1 | Hop countdown in progress |

## Verification
The bench uses the default build: a 32-bit tuning word, 16-bit counts, four pins and two synchronizer stages. With these values every pin code and the two-cycle pin latency can be reached. Counts are kept between 0 and 12, so each countdown ends within a few cycles, and many random trials fit in the run alongside the directed edges. The directed cases cover a shadow write one cycle before the hop edge and one on the hop edge, and a repeat sync on the expiry edge. They also cover a count rewrite during a countdown and every pin code, each exercised both enabled and unselected.

// File: rtl/syncHoldPkg.sv
package syncHoldPkg;
  // Function index: start is slot 0, hop is slot 1
  typedef enum logic {FN_START = 1'b0, FN_HOP = 1'b1} syncFn_e;
  localparam int NUM_FN = 2;

  // Strobes from control to datapath, one per expiring countdown
  typedef struct packed {
    logic hopLoad;
    logic startFire;
  } ctrlStrobe_t;
endpackage

// File: rtl/syncPinEdge.sv
module syncPinEdge #(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinRise
);
  // Per pin: SYNC_STAGES flops for metastability, plus one history flop
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_STAGES:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[SYNC_STAGES-1:0], pinIn[p]};
    end
    assign pinRise[p] = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
  end
endmodule

// File: rtl/syncHoldCtrl.sv
module syncHoldCtrl
  import syncHoldPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PINS-1:0]            syncPins,
  input  logic [NUM_FN-1:0]              softSync,
  input  logic [NUM_FN-1:0]              pinEn,
  input  logic [NUM_FN-1:0][SEL_W-1:0]   pinSel,
  input  logic [NUM_FN-1:0][CNT_W-1:0]   holdCnt,
  output ctrlStrobe_t                    strobe,
  output logic [NUM_FN-1:0]              busy
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [NUM_PINS-1:0] pinRise;
  logic [NUM_FN-1:0]   fire;

  syncPinEdge #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_pinEdge (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (syncPins),
    .pinRise(pinRise)
  );

  // One hold-off countdown per function
  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    logic             counting;
    logic [CNT_W-1:0] remain;
    logic             syncEvt;
    logic             expire;

    always_comb syncEvt = softSync[f] | (pinEn[f] & pinRise[pinSel[f]]);
    always_comb expire  = counting && (remain == CNT_ONE);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        counting <= 1'b0;
        remain   <= '0;
      end else if (!counting) begin
        if (syncEvt) begin
          counting <= 1'b1;
          remain   <= (holdCnt[f] == '0) ? CNT_ONE : holdCnt[f];
        end
      end else if (expire) begin
        counting <= 1'b0;
      end else begin
        remain <= remain - CNT_ONE;
      end
    end

    assign busy[f] = counting;
    assign fire[f] = expire;
  end

  always_comb begin
    strobe.hopLoad   = fire[FN_HOP];
    strobe.startFire = fire[FN_START];
  end
endmodule

// File: rtl/syncHoldData.sv
module syncHoldData
  import syncHoldPkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         freqWrEn,
  input  logic [FREQ_W-1:0]            freqWrData,
  input  logic [NUM_FN-1:0]            cntWrEn,
  input  logic [CNT_W-1:0]             cntWrData,
  input  ctrlStrobe_t                  strobe,
  output logic [NUM_FN-1:0][CNT_W-1:0] holdCnt,
  output logic [FREQ_W-1:0]            shadowFreq,
  output logic [FREQ_W-1:0]            activeFreq,
  output logic                         hopPulse,
  output logic                         startPulse
);
  // Programmed hold-off counts
  for (genvar f = 0; f < NUM_FN; f++) begin : g_cnt
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           cntQ <= '0;
      else if (cntWrEn[f]) cntQ <= cntWrData;
    end
    assign holdCnt[f] = cntQ;
  end

  // Shadow then active tuning word, plus registered pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowFreq <= '0;
      activeFreq <= '0;
      hopPulse   <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      if (freqWrEn)       shadowFreq <= freqWrData;
      if (strobe.hopLoad) activeFreq <= shadowFreq;
      hopPulse   <= strobe.hopLoad;
      startPulse <= strobe.startFire;
    end
  end
endmodule

// File: rtl/syncHoldOff.sv
module syncHoldOff
  import syncHoldPkg::*;
#(
  parameter int  FREQ_W      = 32,
  parameter int  CNT_W       = 16,
  parameter int  NUM_PINS    = 4,
  parameter int  SYNC_STAGES = 2,
  localparam int SEL_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                freqWrEn,
  input  logic [FREQ_W-1:0]   freqWrData,
  input  logic                startCntWrEn,
  input  logic                hopCntWrEn,
  input  logic [CNT_W-1:0]    cntWrData,
  input  logic                softStart,
  input  logic                softHop,
  input  logic [NUM_PINS-1:0] syncPins,
  input  logic                startPinEn,
  input  logic [SEL_W-1:0]    startPinSel,
  input  logic                hopPinEn,
  input  logic [SEL_W-1:0]    hopPinSel,
  output logic [FREQ_W-1:0]   activeFreq,
  output logic                hopPulse,
  output logic                startPulse,
  output logic                startBusy,
  output logic                hopBusy
);
  ctrlStrobe_t                  strobe;
  logic [NUM_FN-1:0]            busy;
  logic [NUM_FN-1:0][CNT_W-1:0] holdCnt;
  logic [FREQ_W-1:0]            shadowFreq;

  syncHoldCtrl #(
    .CNT_W      (CNT_W),
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES),
    .SEL_W      (SEL_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncPins(syncPins),
    .softSync({softHop, softStart}),
    .pinEn   ({hopPinEn, startPinEn}),
    .pinSel  ({hopPinSel, startPinSel}),
    .holdCnt (holdCnt),
    .strobe  (strobe),
    .busy    (busy)
  );

  syncHoldData #(
    .FREQ_W(FREQ_W),
    .CNT_W (CNT_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .freqWrEn  (freqWrEn),
    .freqWrData(freqWrData),
    .cntWrEn   ({hopCntWrEn, startCntWrEn}),
    .cntWrData (cntWrData),
    .strobe    (strobe),
    .holdCnt   (holdCnt),
    .shadowFreq(shadowFreq),
    .activeFreq(activeFreq),
    .hopPulse  (hopPulse),
    .startPulse(startPulse)
  );

  assign startBusy = busy[FN_START];
  assign hopBusy   = busy[FN_HOP];
endmodule

// File: rtl/syncHoldOffChk.sv
module syncHoldOffChk #(
  parameter int FREQ_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              softHop,
  input logic              softStart,
  input logic              hopPulse,
  input logic              startPulse,
  input logic              hopBusy,
  input logic              startBusy,
  input logic [FREQ_W-1:0] activeFreq,
  input logic [FREQ_W-1:0] shadowFreq
);
  AST_ACTIVE_ONLY_ON_HOP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeFreq) |-> hopPulse); // R2

  AST_HOP_TAKES_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    hopPulse |-> activeFreq == $past(shadowFreq)); // R5

  AST_HOP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    hopPulse |=> !hopPulse); // R5

  AST_HOP_ENDS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    hopPulse |-> (!hopBusy && $past(hopBusy))); // R3

  AST_SOFT_ARMS_HOP: assert property (@(posedge clk) disable iff (!rstN)
    (softHop && !hopBusy) |=> hopBusy); // R3

  AST_SOFT_ARMS_START: assert property (@(posedge clk) disable iff (!rstN)
    (softStart && !startBusy) |=> startBusy); // R6

  AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse); // R6

  AST_START_ENDS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (!startBusy && $past(startBusy))); // R6
endmodule

bind syncHoldOff syncHoldOffChk #(.FREQ_W(FREQ_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .softHop   (softHop),
  .softStart (softStart),
  .hopPulse  (hopPulse),
  .startPulse(startPulse),
  .hopBusy   (hopBusy),
  .startBusy (startBusy),
  .activeFreq(activeFreq),
  .shadowFreq(shadowFreq)
);

// File: tb/syncHoldOff_bench.sv
`timescale 1ns/1ps
module syncHoldOff_bench;
  localparam int FREQ_W = 32;
  localparam int CNT_W  = 16;
  localparam int NPINS  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              freqWrEn = 1'b0;
  logic [FREQ_W-1:0] freqWrData = '0;
  logic              startCntWrEn = 1'b0;
  logic              hopCntWrEn = 1'b0;
  logic [CNT_W-1:0]  cntWrData = '0;
  logic              softStart = 1'b0;
  logic              softHop = 1'b0;
  logic [NPINS-1:0]  syncPins = '0;
  logic              startPinEn = 1'b0;
  logic [1:0]        startPinSel = '0;
  logic              hopPinEn = 1'b0;
  logic [1:0]        hopPinSel = '0;
  logic [FREQ_W-1:0] activeFreq;
  logic              hopPulse, startPulse, startBusy, hopBusy;

  int checks = 0;
  int fails = 0;
  int progCnt [2];
  logic [FREQ_W-1:0] expShadow = '0;
  logic [FREQ_W-1:0] expActive = '0;
  bit finished = 1'b0;

  syncHoldOff u_syncHoldOff (
    .clk(clk), .rstN(rstN),
    .freqWrEn(freqWrEn), .freqWrData(freqWrData),
    .startCntWrEn(startCntWrEn), .hopCntWrEn(hopCntWrEn), .cntWrData(cntWrData),
    .softStart(softStart), .softHop(softHop), .syncPins(syncPins),
    .startPinEn(startPinEn), .startPinSel(startPinSel),
    .hopPinEn(hopPinEn), .hopPinSel(hopPinSel),
    .activeFreq(activeFreq), .hopPulse(hopPulse), .startPulse(startPulse),
    .startBusy(startBusy), .hopBusy(hopBusy)
  );

  function automatic bit busyOf(int fn);
    return (fn == 1) ? hopBusy : startBusy;
  endfunction

  function automatic bit pulseOf(int fn);
    return (fn == 1) ? hopPulse : startPulse;
  endfunction

  // Expected countdown length from the programmed count (R4: 0 acts as 1)
  function automatic int holdLen(int cnt);
    return (cnt == 0) ? 1 : cnt;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic wrFreq(logic [FREQ_W-1:0] v);
    freqWrEn = 1'b1; freqWrData = v;
    @(posedge clk); @(negedge clk);
    freqWrEn = 1'b0;
    expShadow = v;
  endtask

  task automatic wrCnt(int fn, int v);
    cntWrData = CNT_W'(v);
    if (fn == 1) hopCntWrEn = 1'b1; else startCntWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    hopCntWrEn = 1'b0; startCntWrEn = 1'b0;
    progCnt[fn] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // One countdown: trigger from software (src<0) or pin src, check busy and
  // pulse cycle by cycle, optional extra sync, count write and shadow write.
  task automatic runTrial(int fn, int src, int extraAt, int midCntAt, int midCnt,
                          int midValAt, logic [FREQ_W-1:0] midVal, string req);
    int lat;
    int d;
    int bad;
    int badK;
    int actB, actP, expB, expP;
    logic [FREQ_W-1:0] act0;
    logic [FREQ_W-1:0] fireVal;
    lat = holdLen(progCnt[fn]);
    d = (src < 0) ? 0 : 2;
    bad = 0; badK = -1; actB = 0; actP = 0; expB = 0; expP = 0;
    act0 = expActive;
    fireVal = (midValAt >= 0 && midValAt <= lat + d - 2) ? midVal : expShadow;
    startPinEn = 1'b0; hopPinEn = 1'b0;
    if (src >= 0) begin
      if (fn == 1) begin hopPinEn = 1'b1; hopPinSel = 2'(src); end
      else begin startPinEn = 1'b1; startPinSel = 2'(src); end
      syncPins[src] = 1'b1;
    end else begin
      if (fn == 1) softHop = 1'b1; else softStart = 1'b1;
    end
    @(posedge clk);
    for (int k = 0; k <= lat + d + 4; k++) begin
      bit eb;
      bit ep;
      logic [FREQ_W-1:0] ea;
      if (k > 0) @(posedge clk);
      @(negedge clk);
      softHop = 1'b0; softStart = 1'b0;
      freqWrEn = 1'b0; hopCntWrEn = 1'b0; startCntWrEn = 1'b0;
      eb = (k >= d) && (k < lat + d);
      ep = (k == lat + d);
      ea = (fn == 1 && k >= lat + d) ? fireVal : act0;
      if (busyOf(fn) != eb || pulseOf(fn) != ep || activeFreq != ea) begin
        if (bad == 0) begin
          badK = k; actB = busyOf(fn); actP = pulseOf(fn); expB = eb; expP = ep;
        end
        bad++;
      end
      if (k == extraAt) begin
        if (fn == 1) softHop = 1'b1; else softStart = 1'b1;
      end
      if (k == midCntAt) begin
        cntWrData = CNT_W'(midCnt);
        if (fn == 1) hopCntWrEn = 1'b1; else startCntWrEn = 1'b1;
      end
      if (k == midValAt) begin
        freqWrEn = 1'b1; freqWrData = midVal;
      end
    end
    if (bad != 0)
      $display("FAIL %s cycle %0d after sync: busy/pulse actual %0d/%0d expected %0d/%0d",
               req, badK, actB, actP, expB, expP);
    checks++;
    if (bad != 0) fails++;
    if (fn == 1) expActive = fireVal;
    if (midValAt >= 0) expShadow = midVal;
    if (midCntAt >= 0) progCnt[fn] = midCnt;
    check(activeFreq == expActive, req, "activeFreq after trial", activeFreq, expActive);
    syncPins = '0; startPinEn = 1'b0; hopPinEn = 1'b0;
    idle(4);
  endtask

  // Nothing may start: busy and pulse of fn stay low for n cycles
  task automatic quiet(int fn, int n, string req);
    int bad;
    bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (busyOf(fn) || pulseOf(fn)) bad++;
    end
    check(bad == 0, req, "cycles with busy or pulse while no sync expected", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (all requirements): run hung, actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4021);
    progCnt[0] = 0; progCnt[1] = 0;
    repeat (3) @(negedge clk);
    check(activeFreq == '0, "R1", "activeFreq in reset", activeFreq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(activeFreq == '0 && !hopPulse && !startPulse, "R1", "outputs after reset",
          {activeFreq != '0, hopPulse, startPulse}, 0);
    check(!hopBusy && !startBusy, "R1", "busy after reset", {hopBusy, startBusy}, 0);
    // R1 reset counts are 0: sync acts after one cycle (R4 rule)
    runTrial(1, -1, -1, -1, 0, -1, '0, "R1");

    // R2: shadow write alone does not move the active word
    wrFreq(32'hA5A5_0001);
    idle(5);
    check(activeFreq == expActive, "R2", "activeFreq after shadow write", activeFreq, expActive);
    wrCnt(1, 5);
    runTrial(1, -1, -1, -1, 0, -1, '0, "R3");
    wrCnt(1, 1);
    runTrial(1, -1, -1, -1, 0, -1, '0, "R3");
    wrCnt(1, 0);
    wrFreq(32'h1234_5678);
    runTrial(1, -1, -1, -1, 0, -1, '0, "R4");

    // R5: shadow write one cycle before the hop edge is taken, on it is not
    wrCnt(1, 6);
    wrFreq(32'h0000_1111);
    runTrial(1, -1, -1, -1, 0, 4, 32'h0000_2222, "R5");
    wrFreq(32'h0000_3333);
    runTrial(1, -1, -1, -1, 0, 5, 32'h0000_4444, "R5");

    // R6: start function
    wrCnt(0, 3);
    runTrial(0, -1, -1, -1, 0, -1, '0, "R6");
    wrCnt(0, 0);
    runTrial(0, 1, -1, -1, 0, -1, '0, "R6");

    // R8: sync during countdown and on the expiry edge are ignored
    wrCnt(1, 8);
    runTrial(1, -1, 3, -1, 0, -1, '0, "R8");
    runTrial(1, -1, 7, -1, 0, -1, '0, "R8");
    wrCnt(0, 4);
    runTrial(0, 0, 4, -1, 0, -1, '0, "R8");

    // R9: count rewritten mid-countdown applies to the next sync
    wrCnt(1, 5);
    runTrial(1, -1, -1, 1, 12, -1, '0, "R9");
    runTrial(1, -1, -1, -1, 0, -1, '0, "R9");

    // R7: each pin code, held level, unselected pins ignored
    wrCnt(1, 3);
    for (int p = 0; p < NPINS; p++) begin
      wrFreq(32'hC000_0000 + 32'(p));
      runTrial(1, p, -1, -1, 0, -1, '0, "R7");
    end
    hopPinEn = 1'b1; hopPinSel = 2'd2;
    syncPins = 4'b1011;
    quiet(1, 8, "R7");
    syncPins = '0; hopPinEn = 1'b0;
    idle(4);

    // R10: selected pin with enable low
    hopPinEn = 1'b0; hopPinSel = 2'd1;
    syncPins = 4'b0010;
    quiet(1, 8, "R10");
    startPinEn = 1'b0; startPinSel = 2'd3;
    syncPins = 4'b1000;
    quiet(0, 8, "R10");
    syncPins = '0;
    idle(4);

    // Random trials across both functions and all sources
    for (int i = 0; i < 40; i++) begin
      int fn;
      int src;
      fn = int'($urandom_range(1, 0));
      wrCnt(fn, int'($urandom_range(12, 0)));
      if (fn == 1) wrFreq($urandom);
      src = int'($urandom_range(4, 0)) - 1;
      runTrial(fn, src, -1, -1, 0, -1, '0, (fn == 1) ? ((src < 0) ? "R3" : "R7") : "R6");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule